// File: doc/BRIEF.md
# CBR Refresh and Self-Refresh Engine

This block keeps the contents of an asynchronous DRAM array alive. An internal interval timer counts clock cycles and, each time it expires, adds one owed refresh to a saturating pending count. While refreshes are owed and the engine is idle, it raises a request to the access controller. Once granted, it takes the row strobe, column strobe and write-enable pins and runs CAS-before-RAS refresh cycles back-to-back until nothing is owed. No row address is produced, because the DRAM advances its own internal refresh counter on each such cycle. The default interval of 3120 cycles at 200 MHz spreads 2048 cycles over roughly 32 ms.

Each refresh cycle drops the column strobe first, drops the row strobe a set number of cycles later, holds both low for the minimum row-active time, and then releases both for the precharge time. Write enable is never driven low. A busy status covers the whole span from the grant to the end of the last precharge, so the access controller starts nothing early.

A low-power self-refresh mode is entered on command. The entry is a CAS-before-RAS sequence in which both strobes stay low for at least a minimum dwell time and for as long as the mode lasts. An exit command is honoured only once that dwell has elapsed. The engine then holds both strobes high for a long exit precharge and runs one ordinary refresh cycle. After that it restarts the interval timer from zero. Refreshes owed when the mode is entered are dropped, because the array refreshes itself while in the mode.

Top module: `refresh_engine`

## Requirements
- R1: While reset is held, and in the cycle after it, ras_n, cas_n and we_n are 1 and ref_req, busy and in_sr are 0.
- R2: When the engine is idle and nothing is owed, ref_req rises exactly REF_INTERVAL cycles after the timer starts from zero (after reset, or after the cycle that follows a self-refresh exit).
- R3: ref_req is 1 only while busy is 0. It stays 1 until grant is sampled high. Without a grant, ras_n and cas_n stay 1.
- R4: A refresh cycle starts in the cycle after the grant edge. It holds cas_n=0 with ras_n=1 for T_CSR cycles, then both at 0 for T_RAS cycles, then both at 1 for T_RP cycles. cas_n is 0 whenever ras_n is 0.
- R5: we_n is 1 in every cycle.
- R6: Owed refreshes add up to at most MAX_PEND. Once granted, they run back-to-back, with consecutive row-strobe falls exactly T_CSR+T_RAS+T_RP cycles apart.
- R7: busy is 1 from the cycle after the grant edge until the last precharge cycle, and 0 otherwise. A burst of n refreshes keeps busy high for exactly n*(T_CSR+T_RAS+T_RP) cycles.
- R8: A pulse on sr_enter is remembered and raises ref_req. After the grant, the engine gives T_CSR cycles of column-first lead. It then holds ras_n=0 and cas_n=0 for at least T_RASS cycles.
- R9: sr_exit is acted on only in self-refresh. If it arrives before T_RASS cycles have passed, the row strobe still stays low for exactly T_RASS cycles. A pulse outside self-refresh has no effect.
- R10: After exit, both strobes stay high for T_RPS cycles. One ordinary refresh cycle follows, with a T_CSR lead. The timer then restarts from zero.
- R11: in_sr is 1 while the strobes are held low in self-refresh and during the exit precharge, and 0 otherwise.
- R12: Refreshes owed when self-refresh is entered are discarded. The whole entry-to-exit span contains exactly two row-strobe falls, and ref_req is 0 when busy falls afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Access controller hands the strobe pins to the engine |
| sr_enter | input | 1 | Pulse: request self-refresh entry |
| sr_exit | input | 1 | Pulse: request self-refresh exit |
| ref_req | output | 1 | Engine asks for the strobe pins |
| busy | output | 1 | Engine owns the strobe pins |
| in_sr | output | 1 | Self-refresh hold or exit precharge in progress |
| ras_n | output | 1 | Row strobe drive, active low |
| cas_n | output | 1 | Column strobe drive, active low |
| we_n | output | 1 | Write-enable drive, held high |

## Verification
The strobes, busy and in_sr are registered from the next phase, so each responds one clock after the edge that samples a grant, a timer expiry or an exit. ref_req is decoded from registers and rises one edge after the timer expiry that creates the owed refresh. A behavioural model steps on the same rising edge as the design and is compared with the outputs on the following falling edge. Directed checks measure run lengths in whole cycles: the column-first lead, the row-low time, the spacing between falls, the self-refresh dwell, the exit gap, and the count from busy falling to the next request. They read these only after the monitor has seen the closing transition.

// File: rtl/refresh_engine_pkg.sv
package refresh_engine_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LEAD = 3'd1,
    PH_ROWLO = 3'd2,
    PH_PRECH = 3'd3,
    PH_SRHOLD = 3'd4,
    PH_SREXIT = 3'd5
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int REF_INTERVAL = 3120,
  parameter int MAX_PEND     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic take,
  input  logic clr,
  output logic pend_nz
);
  localparam int TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [TW-1:0] T_LAST = TW'(REF_INTERVAL - 1);
  localparam logic [PW-1:0] P_MAX  = PW'(MAX_PEND);

  logic [TW-1:0] tmr;
  logic [PW-1:0] pend, pend_n;
  logic          tick, inc, dec;

  assign tick = !hold && (tmr == T_LAST);
  assign inc  = tick && (pend != P_MAX);
  assign dec  = take && (pend != '0);

  always_ff @(posedge clk) begin
    if (rst || hold) tmr <= '0;
    else if (tmr == T_LAST) tmr <= '0;
    else tmr <= tmr + TW'(1);
  end

  always_comb begin
    pend_n = pend;
    if (inc && !dec) pend_n = pend + PW'(1);
    else if (dec && !inc) pend_n = pend - PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pend <= '0;
    else pend <= pend_n;
  end

  assign pend_nz = (pend != '0);

  // R6: a full count stays full when no refresh is taken
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (pend == P_MAX && !take && !clr) |=> (pend == P_MAX));

  // R12: owed refreshes are gone while self-refresh holds the timer
  p_pend_dropped_r12: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pend == '0));

  // R2: a held timer produces no owed refresh
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (hold && !pend_nz) |=> !pend_nz);

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_engine_pkg::*;
#(
  parameter int T_CSR  = 1,
  parameter int T_RAS  = 12,
  parameter int T_RP   = 8,
  parameter int T_RASS = 20000,
  parameter int T_RPS  = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic sr_enter,
  input  logic sr_exit,
  input  logic pend_nz,
  output logic take,
  output logic hold,
  output logic clr,
  output logic ref_req,
  output logic busy,
  output logic in_sr,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int MAXD = imax(imax(imax(T_CSR, T_RAS), imax(T_RP, T_RPS)), T_RASS);
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] L_CSR  = CW'(T_CSR - 1);
  localparam logic [CW-1:0] L_RAS  = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_RASS = CW'(T_RASS - 1);
  localparam logic [CW-1:0] L_RPS  = CW'(T_RPS - 1);

  phase_t        st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          srm, srm_n;     // current sequence leads into self-refresh
  logic          post, post_n;   // single refresh after self-refresh exit
  logic          sr_want, ex_want;
  logic          launch_sr;

  assign ref_req = (st == PH_IDLE) && (pend_nz || sr_want);
  assign hold    = srm || post;
  assign clr     = srm;

  always_comb begin
    st_n      = st;
    cnt_n     = (cnt != '0) ? cnt - CW'(1) : cnt;
    srm_n     = srm;
    post_n    = post;
    launch_sr = 1'b0;
    take      = 1'b0;
    unique case (st)
      PH_IDLE: if (ref_req && grant) begin
        st_n      = PH_LEAD;
        cnt_n     = L_CSR;
        srm_n     = sr_want;
        post_n    = 1'b0;
        launch_sr = sr_want;
      end
      PH_LEAD: if (cnt == '0) begin
        if (srm) begin
          st_n  = PH_SRHOLD;
          cnt_n = L_RASS;
        end else begin
          st_n  = PH_ROWLO;
          cnt_n = L_RAS;
          take  = !post;
        end
      end
      PH_ROWLO: if (cnt == '0) begin
        st_n  = PH_PRECH;
        cnt_n = L_RP;
      end
      PH_PRECH: if (cnt == '0) begin
        if (post) begin
          st_n   = PH_IDLE;
          post_n = 1'b0;
        end else if (sr_want) begin
          st_n      = PH_LEAD;
          cnt_n     = L_CSR;
          srm_n     = 1'b1;
          launch_sr = 1'b1;
        end else if (pend_nz) begin
          st_n  = PH_LEAD;
          cnt_n = L_CSR;
        end else begin
          st_n = PH_IDLE;
        end
      end
      PH_SRHOLD: if (cnt == '0 && (ex_want || sr_exit)) begin
        st_n  = PH_SREXIT;
        cnt_n = L_RPS;
      end
      PH_SREXIT: if (cnt == '0) begin
        st_n   = PH_LEAD;
        cnt_n  = L_CSR;
        srm_n  = 1'b0;
        post_n = 1'b1;
      end
      default: st_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      cnt     <= '0;
      srm     <= 1'b0;
      post    <= 1'b0;
      sr_want <= 1'b0;
      ex_want <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      busy    <= 1'b0;
      in_sr   <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      srm     <= srm_n;
      post    <= post_n;
      sr_want <= launch_sr ? 1'b0 : (sr_want || (sr_enter && !srm));
      ex_want <= (st == PH_SRHOLD) ? (ex_want || sr_exit) : 1'b0;
      ras_n   <= !(st_n == PH_ROWLO || st_n == PH_SRHOLD);
      cas_n   <= !(st_n == PH_LEAD || st_n == PH_ROWLO || st_n == PH_SRHOLD);
      we_n    <= 1'b1;
      busy    <= (st_n != PH_IDLE);
      in_sr   <= (st_n == PH_SRHOLD || st_n == PH_SREXIT);
    end
  end

  // R4: the column strobe leads the row strobe by at least one cycle
  p_cas_lead_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R4: the column strobe covers every row-low cycle
  p_cas_cover_r4: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cas_n);

  // R7: strobe activity only while the pins are owned
  p_strobe_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !cas_n) |-> busy);

  // R3: no request while the pins are owned
  p_req_idle_r3: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> !busy);

  // R3: without a grant an idle engine stays idle
  p_no_grant_r3: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE && !grant) |=> !busy);

  // R10: exit precharge keeps both strobes high
  p_exit_high_r10: assert property (@(posedge clk) disable iff (rst)
    (st == PH_SREXIT) |-> (ras_n && cas_n && in_sr));

  // R11: self-refresh hold drives both strobes low
  p_hold_low_r11: assert property (@(posedge clk) disable iff (rst)
    (st == PH_SRHOLD) |-> (in_sr && !ras_n && !cas_n));

endmodule

// File: rtl/refresh_engine.sv
module refresh_engine #(
  parameter int REF_INTERVAL = 3120,
  parameter int MAX_PEND     = 8,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 12,
  parameter int T_RP         = 8,
  parameter int T_RASS       = 20000,
  parameter int T_RPS        = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic ref_req,
  output logic busy,
  output logic in_sr,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  logic hold, take, clr, pend_nz;

  refresh_timer #(
    .REF_INTERVAL(REF_INTERVAL),
    .MAX_PEND    (MAX_PEND)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .hold   (hold),
    .take   (take),
    .clr    (clr),
    .pend_nz(pend_nz)
  );

  refresh_seq #(
    .T_CSR (T_CSR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP),
    .T_RASS(T_RASS),
    .T_RPS (T_RPS)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .grant   (grant),
    .sr_enter(sr_enter),
    .sr_exit (sr_exit),
    .pend_nz (pend_nz),
    .take    (take),
    .hold    (hold),
    .clr     (clr),
    .ref_req (ref_req),
    .busy    (busy),
    .in_sr   (in_sr),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n)
  );

  initial begin
    if (T_CSR < 1 || T_RAS < 1 || T_RP < 1 || T_RASS < 1 || T_RPS < 1 ||
        REF_INTERVAL < 2 || MAX_PEND < 1)
      $error("refresh_engine: timing parameters must be positive");
  end

endmodule

// File: tb/refresh_engine_test.sv
`timescale 1ns/1ps
module refresh_engine_test;
  localparam int IV     = 100;
  localparam int MAXP   = 3;
  localparam int TCSR   = 2;
  localparam int TRAS   = 12;
  localparam int TRP    = 8;
  localparam int TRASS  = 60;
  localparam int TRPS   = 21;
  localparam int PERIOD = TCSR + TRAS + TRP;
  localparam int WD_CYC = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
  logic ref_req, busy, in_sr, ras_n, cas_n, we_n;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  refresh_engine #(
    .REF_INTERVAL(IV), .MAX_PEND(MAXP), .T_CSR(TCSR), .T_RAS(TRAS),
    .T_RP(TRP), .T_RASS(TRASS), .T_RPS(TRPS)
  ) uut (
    .clk(clk), .rst(rst), .grant(grant), .sr_enter(sr_enter), .sr_exit(sr_exit),
    .ref_req(ref_req), .busy(busy), .in_sr(in_sr),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 lead, 2 row low, 3 precharge, 4 sr hold, 5 sr exit
  int m_ph = 0, m_cnt = 0, m_tmr = 0, m_pend = 0;
  bit m_srm = 0, m_post = 0, m_srw = 0, m_exw = 0;

  task automatic model_step(input bit g, input bit en, input bit ex);
    int  o_ph = m_ph, o_cnt = m_cnt, o_tmr = m_tmr, o_pend = m_pend;
    bit  o_srm = m_srm, o_post = m_post, o_srw = m_srw, o_exw = m_exw;
    bit  req, take, launch, tick, hold;
    req = (o_ph == 0) && (o_pend > 0 || o_srw);
    take = 0; launch = 0;
    if (o_cnt > 0) m_cnt = o_cnt - 1;
    case (o_ph)
      0: if (req && g) begin m_ph = 1; m_cnt = TCSR - 1; m_srm = o_srw; m_post = 0; launch = o_srw; end
      1: if (o_cnt == 0) begin
           if (o_srm) begin m_ph = 4; m_cnt = TRASS - 1; end
           else begin m_ph = 2; m_cnt = TRAS - 1; take = !o_post; end
         end
      2: if (o_cnt == 0) begin m_ph = 3; m_cnt = TRP - 1; end
      3: if (o_cnt == 0) begin
           if (o_post) begin m_ph = 0; m_post = 0; end
           else if (o_srw) begin m_ph = 1; m_cnt = TCSR - 1; m_srm = 1; launch = 1; end
           else if (o_pend > 0) begin m_ph = 1; m_cnt = TCSR - 1; end
           else m_ph = 0;
         end
      4: if (o_cnt == 0 && (o_exw || ex)) begin m_ph = 5; m_cnt = TRPS - 1; end
      5: if (o_cnt == 0) begin m_ph = 1; m_cnt = TCSR - 1; m_srm = 0; m_post = 1; end
      default: m_ph = 0;
    endcase
    m_srw = launch ? 0 : (o_srw || (en && !o_srm));
    m_exw = (o_ph == 4) ? (o_exw || ex) : 0;
    hold = o_srm || o_post;
    tick = 0;
    if (hold) m_tmr = 0;
    else if (o_tmr == IV - 1) begin m_tmr = 0; tick = 1; end
    else m_tmr = o_tmr + 1;
    if (o_srm) m_pend = 0;
    else m_pend = o_pend + ((tick && o_pend < MAXP) ? 1 : 0) - ((take && o_pend > 0) ? 1 : 0);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_tmr = 0; m_pend = 0;
      m_srm = 0; m_post = 0; m_srw = 0; m_exw = 0;
    end else model_step(grant, sr_enter, sr_exit);
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(ras_n === !(m_ph == 2 || m_ph == 4), "R4 ras_n vs model", ras_n, !(m_ph == 2 || m_ph == 4));
      chk(cas_n === !(m_ph == 1 || m_ph == 2 || m_ph == 4), "R4 cas_n vs model", cas_n,
          !(m_ph == 1 || m_ph == 2 || m_ph == 4));
      chk(we_n === 1'b1, "R5 we_n high", we_n, 1);
      chk(busy === (m_ph != 0), "R7 busy vs model", busy, m_ph != 0);
      chk(in_sr === (m_ph == 4 || m_ph == 5), "R11 in_sr vs model", in_sr, m_ph == 4 || m_ph == 5);
      chk(ref_req === ((m_ph == 0) && (m_pend > 0 || m_srw)), "R3 ref_req vs model", ref_req,
          (m_ph == 0) && (m_pend > 0 || m_srw));
    end
  end

  // ---------------- run-length monitor (sees previous-cycle values) ----------------
  int cyc = 0, ras_lo_run = 0, ras_hi_run = 0, cas_run = 0;
  int last_ras_lo = 0, last_ras_hi = 0, last_cas_lead = 0, ras_falls = 0;
  int last_fall_cyc = 0, last_gap = 0;
  bit prev_ras = 1;

  always @(posedge clk) begin
    cyc++;
    if (!ras_n) begin
      if (prev_ras) begin
        ras_falls++;
        last_gap = cyc - last_fall_cyc;
        last_fall_cyc = cyc;
        last_ras_hi = ras_hi_run;
        last_cas_lead = cas_run;
      end
      ras_lo_run++;
      ras_hi_run = 0;
    end else begin
      if (!prev_ras) last_ras_lo = ras_lo_run;
      ras_lo_run = 0;
      ras_hi_run++;
    end
    cas_run = !cas_n ? cas_run + 1 : 0;
    prev_ras = ras_n;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(WD_CYC * 5.0);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n, f0, bcyc, viol;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !busy && !in_sr, "R1 status low in reset", {ref_req, busy, in_sr}, 0);
    rst = 1'b0;
    // R2: first request exactly IV cycles after timer start
    n = 0;
    for (int i = 0; i < 3 * IV && !ref_req; i++) begin @(negedge clk); n++; end
    chk(n == IV, "R2 first request latency", n, IV);
    // R3: no grant, no strobes, request held
    viol = 0;
    for (int i = 0; i < 4 * IV; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n || !ref_req) viol++;
    end
    chk(viol == 0, "R3 request held and strobes idle without grant", viol, 0);
    // R6 / R7 / R4: saturated burst
    grant = 1'b1;
    for (int i = 0; i < 10 && !busy; i++) @(negedge clk);
    f0 = ras_falls; bcyc = 0;
    for (int i = 0; i < 20 * PERIOD && busy; i++) begin bcyc++; @(negedge clk); end
    repeat (2) @(negedge clk);
    n = ras_falls - f0;
    chk(n >= MAXP && n <= MAXP + 1, "R6 burst length saturates", n, MAXP);
    chk(last_gap == PERIOD, "R6 back-to-back spacing", last_gap, PERIOD);
    chk(bcyc == n * PERIOD, "R7 busy span of burst", bcyc, n * PERIOD);
    chk(last_ras_lo == TRAS, "R4 row low time", last_ras_lo, TRAS);
    chk(last_cas_lead == TCSR, "R4 column lead", last_cas_lead, TCSR);
    chk(last_ras_hi >= TRP + TCSR, "R4 precharge before next fall", last_ras_hi, TRP + TCSR);
    // R8 / R9 / R10 / R11: self-refresh with early exit
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;   // stale exit, ignored (R9)
    sr_enter = 1'b1; @(negedge clk); sr_enter = 1'b0;
    for (int i = 0; i < 200 && !(in_sr && !ras_n); i++) @(negedge clk);
    chk(in_sr && !ras_n && !cas_n, "R8 self-refresh hold entered", {in_sr, ras_n, cas_n}, 4);
    repeat (10) @(negedge clk);
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    for (int i = 0; i < 4 * TRASS && !ras_n; i++) @(negedge clk);
    chk(in_sr == 1'b1 && ras_n && cas_n, "R11 in_sr during exit precharge", in_sr, 1);
    repeat (2) @(negedge clk);
    chk(last_ras_lo == TRASS, "R9 early exit deferred to minimum dwell", last_ras_lo, TRASS);
    for (int i = 0; i < 4 * TRPS && ras_n; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(last_ras_hi == TRPS + TCSR, "R10 exit precharge then lead", last_ras_hi, TRPS + TCSR);
    chk(in_sr == 1'b0, "R11 in_sr clear in post-exit refresh", in_sr, 0);
    for (int i = 0; i < 4 * PERIOD && busy; i++) @(negedge clk);
    grant = 1'b0;
    n = 0;
    for (int i = 0; i < 3 * IV && !ref_req; i++) begin @(negedge clk); n++; end
    chk(n == IV, "R10 timer restarts from zero after exit", n, IV);
    // R12 / R9: owed refreshes dropped, stale exit ignored
    repeat (2 * IV + 5) @(negedge clk);
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    sr_enter = 1'b1; @(negedge clk); sr_enter = 1'b0;
    f0 = ras_falls;
    grant = 1'b1;
    for (int i = 0; i < 200 && !in_sr; i++) @(negedge clk);
    repeat (TRASS + 40) @(negedge clk);
    chk(in_sr && !ras_n, "R9 no exit without request after dwell", {in_sr, ras_n}, 2);
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
    for (int i = 0; i < 4 * (TRPS + PERIOD) && busy; i++) @(negedge clk);
    chk(ref_req == 1'b0, "R12 nothing owed after self-refresh", ref_req, 0);
    repeat (2) @(negedge clk);
    chk(ras_falls - f0 == 2, "R12 owed refreshes discarded", ras_falls - f0, 2);
    repeat (50) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule